// File: doc/BRIEF.md
# Fractional Clock-Enable Generator

This block turns a free-running clock into a clock-enable pulse train whose average rate is a programmable fraction of that clock. The fraction is set by a 5-bit field F: the block issues M = 32 − F enables in every 32-cycle frame. F = 0 gives an enable on every cycle, and F = 31 gives one enable per frame. The enables are spread across the frame by an accumulator instead of being issued back to back. Downstream logic gates its work with the enable to run at the reduced rate.

Software uses two word registers on a simple single-cycle bus. A control register at word index 0 holds F in bits 12:8, and every other bit of that register is plain storage. A commit register at word index 1 holds a commit bit in bit 31. A value written to F is only staged. It takes effect after software writes 1 to the commit bit. The commit bit then reads as 1 until hardware has moved the staged ratio into the active shadow at the next frame boundary, and it clears without further software action. Software polls the commit bit and treats the block as busy while it is set.

Because F is five bits, the multiplier M always lies between 1 and 32. No request can reach outside that range.

Top module: `frac_clk_en`

## Requirements
- R1: A control write (word index 0) stores F from bits 12:8 of the write data. Reading the control register returns the stored F in bits 12:8.
- R2: All control bits other than 12:8 are stored as written and read back unchanged, so a read-modify-write of F preserves them.
- R3: While the active ratio is steady, every 32 consecutive cycles of `clk_en_o` contain exactly M = 32 − F enables. The active multiplier always stays within 1..32.
- R4: Enables are spread evenly. Between two enables there are at least floor(32/M) − 1 and at most ceil(32/M) − 1 idle cycles, and there are never more than 31.
- R5: Writing F without committing does not change the output rate.
- R6: A commit write (word index 1) with bit 31 = 1 sets the commit bit, which reads back in bit 31. Commit writes with bit 31 = 0 have no effect. All other bits of the commit register read as 0.
- R7: The commit bit clears by itself at the end of the current 32-cycle frame, within 33 cycles of the commit write. The active ratio changes only in that cycle, and the new rate applies from the next frame.
- R8: While the commit bit is set, control writes leave F unchanged but still update the other control bits.
- R9: After reset, the control register is 0, the commit bit is 0 and the output runs at the full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word index: 0 = control, 1 = commit |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| clk_en_o | output | 1 | Clock-enable pulse train |

## Verification
The bench goes after the extreme ratios. At F = 0 a design that mishandles the carry loses the always-on enable, and at F = 31 an off-by-one accumulator gives two pulses per frame or none. It also sends a kick while a staged value sits unused, to catch a design that applies F the moment it is written. It rewrites F while a commit is pending, to catch a design that would switch to the wrong ratio. Random ratios with random surrounding bits check that a read-modify-write keeps the other bits and that the gap between enables stays within the even-spread bounds, which a burst-style generator would break.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    REG_CTRL   = 2'd0,
    REG_COMMIT = 2'd1
  } reg_idx_e;
endpackage

// File: rtl/frac_regs.sv
module frac_regs
  import frac_clk_pkg::*;
#(
  parameter int unsigned DATA_W    = BUS_DW,
  parameter int unsigned ADDR_W    = BUS_AW,
  parameter int unsigned FRAC_W    = 5,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned KICK_BIT  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FRAC_W-1:0] field_o,
  output logic              busy_o
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}} << FIELD_LSB;

  logic [DATA_W-1:0] ctrl_q;
  logic              busy_q;
  logic              wr_ctrl, wr_commit;

  assign wr_ctrl   = req_i && we_i && (addr_i == REG_CTRL);
  assign wr_commit = req_i && we_i && (addr_i == REG_COMMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      // field frozen while a commit is pending
      if (busy_q) ctrl_q <= (wdata_i & ~FIELD_MASK) | (ctrl_q & FIELD_MASK);
      else        ctrl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       busy_q <= 1'b0;
    else if (done_i)                                   busy_q <= 1'b0;
    else if (wr_commit && wdata_i[KICK_BIT] && !busy_q) busy_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_CTRL)        rdata_o = ctrl_q;
    else if (addr_i == REG_COMMIT) rdata_o[KICK_BIT] = busy_q;
  end

  assign field_o = ctrl_q[FIELD_LSB +: FRAC_W];
  assign busy_o  = busy_q;
endmodule

// File: rtl/frac_commit.sv
module frac_commit #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [FRAC_W-1:0] field_i,
  output logic [FRAC_W:0]   mult_o,
  output logic              done_o
);
  localparam logic [FRAC_W:0] FRAME_V = {1'b1, {FRAC_W{1'b0}}};

  logic [FRAC_W-1:0] frame_q;
  logic [FRAC_W:0]   mult_q;
  logic              frame_last;

  assign frame_last = (frame_q == {FRAC_W{1'b1}});
  assign done_o     = busy_i && frame_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '0;
    else         frame_q <= frame_q + 1'b1;
  end

  // shadow loads only at frame end so no frame mixes two ratios
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mult_q <= FRAME_V;
    else if (done_o) mult_q <= FRAME_V - {1'b0, field_i};
  end

  assign mult_o = mult_q;
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FRAC_W:0] mult_i,
  output logic            en_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic              en_q;

  assign sum = {1'b0, acc_q} + mult_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
      en_q  <= sum[FRAC_W];
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/frac_clk_en.sv
module frac_clk_en
  import frac_clk_pkg::*;
#(
  parameter int unsigned DATA_W    = BUS_DW,
  parameter int unsigned ADDR_W    = BUS_AW,
  parameter int unsigned FRAC_W    = 5,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned KICK_BIT  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              clk_en_o
);
  logic [FRAC_W-1:0] field;
  logic [FRAC_W:0]   mult;
  logic              busy;
  logic              done;

  frac_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
    .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .done_i(done),
    .rdata_o(bus_rdata_o), .field_o(field), .busy_o(busy)
  );

  frac_commit #(.FRAC_W(FRAC_W)) u_commit (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .busy_i(busy), .field_i(field),
    .mult_o(mult), .done_o(done)
  );

  frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mult_i(mult), .en_o(clk_en_o)
  );
endmodule

// File: rtl/frac_clk_en_chk.sv
module frac_clk_en_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned FRAC_W   = 5,
  parameter int unsigned KICK_BIT = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              busy_i,
  input logic [FRAC_W-1:0] field_i,
  input logic [FRAC_W:0]   mult_i,
  input logic              en_i
);
  localparam int unsigned FRAME = 1 << FRAC_W;
  localparam int unsigned CNT_W = FRAC_W + 2;

  logic [CNT_W-1:0] busy_cnt, gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt <= '0;
      gap_cnt  <= '0;
    end else begin
      busy_cnt <= busy_i ? busy_cnt + 1'b1 : '0;
      gap_cnt  <= en_i ? '0 : ((gap_cnt == '1) ? gap_cnt : gap_cnt + 1'b1);
    end
  end

  assert_kick_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= CNT_W'(FRAME));

  assert_ratio_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult_i != $past(mult_i)) |-> $fell(busy_i));

  assert_gap_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_cnt < CNT_W'(FRAME));

  assert_mult_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult_i != '0) && (mult_i <= (FRAC_W+1)'(FRAME)));

  assert_field_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(field_i));

  assert_kick_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(req_i && we_i && (addr_i == ADDR_W'(1)) && wdata_i[KICK_BIT]));
endmodule

bind frac_clk_en frac_clk_en_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .KICK_BIT(KICK_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
  .busy_i(busy), .field_i(field), .mult_i(mult), .en_i(clk_en_o)
);

// File: tb/tb_frac_clk_en.sv
module tb_frac_clk_en;
  localparam logic [31:0] FMASK = 32'h0000_1F00;
  localparam logic [31:0] KICK  = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        en;
  int          checks = 0, errors = 0;
  bit          done_flag = 0;

  always #5 clk = ~clk;

  frac_clk_en dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .clk_en_o(en)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  function automatic int ceil_div(input int n, input int m);
    return (n + m - 1) / m;
  endfunction

  // counts enables in 32 cycles, then zero runs over 64 cycles
  task automatic measure(input int m, input string r);
    int cnt = 0, run = 0, maxrun = 0, minrun = 1000;
    bit seen = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (en) cnt++;
    end
    chk(cnt == m, r, cnt, m);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (en) begin
        if (seen && run > maxrun) maxrun = run;
        if (seen && run < minrun) minrun = run;
        seen = 1; run = 0;
      end else run++;
    end
    if (minrun == 1000) minrun = 32 / m - 1;
    chk(maxrun <= ceil_div(32, m) - 1 && minrun >= 32 / m - 1, "R4 spread",
        {minrun[15:0], maxrun[15:0]}, ceil_div(32, m) - 1);
  endtask

  task automatic wait_idle(output int polls);
    logic [31:0] d;
    polls = 0;
    do begin
      rd(2'd1, d);
      polls++;
    end while (d[31] && polls < 100);
  endtask

  task automatic commit(input int f, input logic [31:0] other);
    logic [31:0] d, v;
    int polls;
    v = (other & ~FMASK) | (32'(f) << 8);
    wr(2'd0, v);
    rd(2'd0, d);
    chk(d[12:8] == 5'(f), "R1 field readback", d, v);
    chk((d & ~FMASK) == (v & ~FMASK), "R2 other bits kept", d, v);
    wr(2'd1, KICK);
    rd(2'd1, d);
    chk(d == KICK, "R6 commit bit set", d, KICK);
    wait_idle(polls);
    chk(polls <= 34, "R7 commit clears in time", polls, 34);
    repeat (40) @(negedge clk);
    measure(32 - f, "R3 rate");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int polls;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(2'd0, d); chk(d == 0, "R9 control reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R9 commit reset", d, 0);
    repeat (4) @(negedge clk);
    measure(32, "R9 full rate");

    // R6 commit writes without bit 31 ignored
    wr(2'd1, 32'h7FFF_FFFF);
    rd(2'd1, d); chk(d == 0, "R6 no kick without bit31", d, 0);

    // directed extremes
    commit(31, 32'h0);
    commit(0, 32'hFFFF_FFFF);
    commit(16, 32'hA5A5_5A5A);
    commit(1, 32'h0000_00FF);

    // R5 staged but not committed
    wr(2'd0, 32'(20) << 8);
    rd(2'd0, d); chk(d[12:8] == 5'd20, "R5 staged readback", d, 32'(20) << 8);
    repeat (70) @(negedge clk);
    measure(31, "R5 staged not applied");

    // R8 write during busy
    wr(2'd0, 32'(7) << 8);
    wr(2'd1, KICK);
    wr(2'd0, 32'h0001_0000 | (32'(25) << 8));
    rd(2'd0, d);
    chk(d == (32'h0001_0000 | (32'(7) << 8)), "R8 field frozen while busy", d,
        32'h0001_0000 | (32'(7) << 8));
    wait_idle(polls);
    chk(polls <= 34, "R7 commit clears in time", polls, 34);
    repeat (40) @(negedge clk);
    measure(25, "R8 ratio from pre-busy field");

    // random ratios
    for (int i = 0; i < 8; i++) commit(int'($urandom % 32), $urandom);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule